// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block is a synthesizable model of a serial memory slave holding 256 words of 16 bits. A bus master reaches it through four lines: a select, a serial clock, a serial data input and a serial data output. All of these are sampled against the system clock. Two mode pins also steer command decoding. The protect-select pin chooses between array commands and protect-register commands. The program-enable pin gates every command that changes state.

A frame has three parts. The first is a start bit, which may follow any number of leading zeros. Then come a 2-bit opcode and an 8-bit address, both MSB first. Write frames end with a 16-bit data word, also MSB first.

A read frame returns one dummy 0 bit and then the data. Reading goes on through the following addresses for as long as the master keeps clocking. Write commands are armed by the frame and committed on the falling edge of select. A write runs for a fixed number of system clocks. While it runs, a selected but idle slave shows busy (0) or ready (1) on the data output.

The block does not hold the protect boundary. It presents the address it is about to write on a query port, and a separate protect block answers whether that address is protected.

The command state machine has seven states:
- `S_IDLE` waits for the start bit.
- `S_OPC` takes the two opcode bits.
- `S_ADDR` takes the eight address bits and decodes the command.
- `S_DATA` takes the sixteen data bits.
- `S_READ` streams words out.
- `S_ARMED` holds a complete write until select falls.
- `S_DONE` ignores further bits.

Transitions:
- Any state goes to `S_IDLE` when select is low or rises.
- `S_IDLE` goes to `S_OPC` on a sampled 1 while no write is running.
- `S_OPC` goes to `S_ADDR` after two bits.
- `S_ADDR` goes to `S_READ` for a read, to `S_DATA` for either write, and to `S_DONE` for everything else.
- `S_DATA` goes to `S_ARMED` after sixteen bits.

Top module: `sereep_slave`

## Requirements
- R1: While select is low, serial clock and data-in activity has no effect on the command state or the array, and the data-out enable is low.
- R2: A rising edge of select restarts command reception. A frame that is cut short by select falling commits nothing.
- R3: Zeros sampled before the first 1 are ignored. The first 1 is the start bit, followed by a 2-bit opcode and an 8-bit address, MSB first, each sampled on a rising serial clock edge.
- R4: With the protect-select pin low, commands decode as follows. Opcode 10 is read and opcode 01 is write-word. Opcode 00 with address bits [7:6] = 11 is unlock, with 01 is fill-all, and with 00 is lock. Any other combination, or any frame with the protect-select pin high, changes neither the array nor the write-enable latch.
- R5: A read drives a dummy 0 from the rising serial edge that samples address bit 0. The stored word then follows, D15 first, with one bit per later rising edge.
- R6: A read that keeps being clocked continues with the next address without a gap, wrapping from 255 to 0.
- R7: The write-enable latch is cleared by reset and by lock. Unlock sets it only while the program-enable pin is high.
- R8: Write-word stores its 16-bit data on the falling edge of select. It does so only if the latch is set, the program-enable pin is high at that edge, and the protect block reports the address as unprotected. No erase is needed first.
- R9: Fill-all stores its data into every address the protect block reports as unprotected and leaves the protected words unchanged.
- R10: After a committed write, the data output is driven while select is high and the slave is idle. It shows 0 for WR_CYCLES system clocks and 1 after that. New start bits are ignored while the write runs.
- R11: After reset every word reads as 16'hFFFF and the data-out enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the master |
| din_i | input | 1 | Serial data in |
| prot_sel_i | input | 1 | Protect-select mode pin (high: protect-register commands, not handled here) |
| wr_allow_i | input | 1 | Program-enable mode pin |
| prot_hit_i | input | 1 | Protect block answer: the queried address is protected |
| prot_addr_o | output | 8 | Address queried from the protect block |
| dout_o | output | 1 | Serial data out (read bits or busy/ready status) |
| dout_oe_o | output | 1 | Output enable for dout_o; low stands for high impedance |

## Verification
The hardest situation to reach is the status window: a write has to be committed and select raised again while the self-timed counter is still running, and only then can busy be observed and later turn to ready. The bench does this by ending a write frame, reselecting the slave a few clocks later with the serial clock held still, and checking the output level both at once and after the write time has run out. The address wrap is reached with a read that starts two words below the top of the array and is clocked across the end. Protected fill-all is reached by moving the bench's protect boundary into the middle of the array and then reading across it.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPC,
        S_ADDR,
        S_DATA,
        S_READ,
        S_ARMED,
        S_DONE
    } sereep_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_READ,
        CMD_WRITE,
        CMD_FILL,
        CMD_UNLOCK,
        CMD_LOCK
    } sereep_cmd_e;

    // R4: command decode from mode pin, opcode and the two top address bits
    function automatic sereep_cmd_e sereep_decode(input logic       prot_sel,
                                                  input logic [1:0] opc,
                                                  input logic [1:0] hi);
        sereep_cmd_e c;
        c = CMD_NONE;
        if (!prot_sel) begin
            unique case (opc)
                2'b10: c = CMD_READ;
                2'b01: c = CMD_WRITE;
                2'b00: begin
                    unique case (hi)
                        2'b11:   c = CMD_UNLOCK;
                        2'b01:   c = CMD_FILL;
                        2'b00:   c = CMD_LOCK;
                        default: c = CMD_NONE;
                    endcase
                end
                default: c = CMD_NONE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sereep_edge.sv
module sereep_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= sig_i;
    end

    assign rise_o = sig_i & ~q;
    assign fall_o = ~sig_i & q;
endmodule

// File: rtl/sereep_store.sv
module sereep_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/sereep_busy_timer.sv
module sereep_busy_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start_i)        cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end

    assign busy_o = (cnt_q != '0);

    // R10: a started write is reported busy on the next cycle
    p_start_sets_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
endmodule

// File: rtl/sereep_slave.sv
module sereep_slave
    import sereep_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int WR_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              sclk_i,
    input  logic              din_i,
    input  logic              prot_sel_i,
    input  logic              wr_allow_i,
    input  logic              prot_hit_i,
    output logic [ADDR_W-1:0] prot_addr_o,
    output logic              dout_o,
    output logic              dout_oe_o
);
    localparam int CNT_W = $clog2(DATA_W + ADDR_W);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    sereep_state_e     state_q, state_d;
    sereep_cmd_e       cmd_q, cmd_now;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [1:0]        opc_q;
    logic [ADDR_W-1:0] addr_q, full_addr, rd_addr, sweep_addr_q, wr_addr;
    logic [DATA_W-1:0] data_q, rd_sh_q, rd_word;
    logic              dout_q, wel_q, stat_q, sweep_q;
    logic              sel_rise, sel_fall, sclk_rise, sclk_fall_unused, sel_unused;
    logic              bit_ev, addr_done, launch, wr_en, tmr_start, tmr_busy, busy;

    sereep_edge #(.W(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({sel_i, sclk_i}),
        .rise_o ({sel_rise, sclk_rise}),
        .fall_o ({sel_fall, sclk_fall_unused})
    );
    assign sel_unused = sclk_fall_unused;

    // a serial bit counts only while selected and not on a select restart
    assign bit_ev    = sel_i && !sel_rise && sclk_rise;
    assign full_addr = {addr_q[ADDR_W-2:0], din_i};
    assign cmd_now   = sereep_decode(prot_sel_i, opc_q, full_addr[ADDR_W-1 -: 2]);
    assign addr_done = bit_ev && (state_q == S_ADDR) && (bit_cnt_q == ADDR_LAST);
    assign busy      = tmr_busy || sweep_q;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (!sel_i || sel_rise) begin
            state_d = S_IDLE;
        end else if (sclk_rise) begin
            unique case (state_q)
                S_IDLE:  if (din_i && !busy) state_d = S_OPC;
                S_OPC:   if (bit_cnt_q == CNT_W'(1)) state_d = S_ADDR;
                S_ADDR:  if (bit_cnt_q == ADDR_LAST) begin
                             unique case (cmd_now)
                                 CMD_READ:            state_d = S_READ;
                                 CMD_WRITE, CMD_FILL: state_d = S_DATA;
                                 default:             state_d = S_DONE;
                             endcase
                         end
                S_DATA:  if (bit_cnt_q == DATA_LAST) state_d = S_ARMED;
                S_READ:  state_d = S_READ;
                S_ARMED: state_d = S_ARMED;
                S_DONE:  state_d = S_DONE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- write launch ----------------
    assign launch    = sel_fall && (state_q == S_ARMED) && wel_q && wr_allow_i && !busy;
    assign tmr_start = launch && ((cmd_q == CMD_FILL) || !prot_hit_i);
    assign wr_en     = (launch && (cmd_q == CMD_WRITE) && !prot_hit_i)
                     || (sweep_q && !prot_hit_i);
    assign wr_addr     = sweep_q ? sweep_addr_q : addr_q;
    assign prot_addr_o = wr_addr;
    assign rd_addr     = (state_q == S_ADDR) ? full_addr : addr_q + ADDR_W'(1);

    sereep_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (data_q),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_word)
    );

    sereep_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .busy_o  (tmr_busy)
    );

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q    <= '0;
            opc_q        <= '0;
            addr_q       <= '0;
            data_q       <= '0;
            rd_sh_q      <= '0;
            cmd_q        <= CMD_NONE;
            dout_q       <= 1'b0;
            wel_q        <= 1'b0;
            stat_q       <= 1'b0;
            sweep_q      <= 1'b0;
            sweep_addr_q <= '0;
        end else begin
            if (sweep_q) begin
                sweep_addr_q <= sweep_addr_q + ADDR_W'(1);
                if (sweep_addr_q == '1) sweep_q <= 1'b0;
            end
            if (tmr_start) begin
                stat_q <= 1'b1;
                if (cmd_q == CMD_FILL) begin
                    sweep_q      <= 1'b1;
                    sweep_addr_q <= '0;
                end
            end
            if (bit_ev) begin
                unique case (state_q)
                    S_IDLE: begin
                        bit_cnt_q <= '0;
                        if (din_i && !busy) stat_q <= 1'b0;
                    end
                    S_OPC: begin
                        opc_q     <= {opc_q[0], din_i};
                        bit_cnt_q <= (bit_cnt_q == CNT_W'(1)) ? '0 : bit_cnt_q + CNT_W'(1);
                    end
                    S_ADDR: begin
                        addr_q <= full_addr;
                        if (bit_cnt_q == ADDR_LAST) begin
                            bit_cnt_q <= '0;
                            cmd_q     <= cmd_now;
                            if (cmd_now == CMD_UNLOCK && wr_allow_i) wel_q <= 1'b1;
                            if (cmd_now == CMD_LOCK)                 wel_q <= 1'b0;
                            if (cmd_now == CMD_READ) begin
                                dout_q  <= 1'b0;
                                rd_sh_q <= rd_word;
                            end
                        end else begin
                            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        end
                    end
                    S_DATA: begin
                        data_q    <= {data_q[DATA_W-2:0], din_i};
                        bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                    end
                    S_READ: begin
                        dout_q <= rd_sh_q[DATA_W-1];
                        if (bit_cnt_q == DATA_LAST) begin
                            bit_cnt_q <= '0;
                            addr_q    <= addr_q + ADDR_W'(1);
                            rd_sh_q   <= rd_word;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                            rd_sh_q   <= {rd_sh_q[DATA_W-2:0], 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        dout_oe_o = 1'b0;
        dout_o    = 1'b0;
        if (sel_i) begin
            if (state_q == S_READ) begin
                dout_oe_o = 1'b1;
                dout_o    = dout_q;
            end else if (state_q == S_IDLE && stat_q) begin
                dout_oe_o = 1'b1;
                dout_o    = !busy;
            end
        end
    end

    // ---------------- assertions ----------------
    // R1: nothing is driven while deselected
    p_quiet_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |-> !dout_oe_o);

    // R5: the cycle after entering the read stream shows the dummy 0
    p_read_dummy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR && state_d == S_READ) |=> (!sel_i || (dout_oe_o && !dout_o)));

    // R8: a single-word store happens only with latch and program enable
    p_write_needs_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sweep_q) |-> (wel_q && wr_allow_i && sel_fall));

    // R7: a decoded lock leaves the latch clear
    p_lock_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && cmd_now == CMD_LOCK) |=> !wel_q);

    // R9: the fill sweep ends after the top address
    p_sweep_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_q && sweep_addr_q == '1) |=> !sweep_q);

    // R10: no new frame starts while a write runs
    p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && busy) |=> (state_q == S_IDLE));
endmodule

// File: tb/test_sereep_slave.sv
module test_sereep_slave;
    localparam int WR_CYC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, sclk = 1'b0, din = 1'b0;
    logic       pre = 1'b0, pe = 1'b0;
    logic [7:0] prot_addr;
    logic       prot_hit, dout, dout_oe;
    int         prot_lim = 256;
    int         n_tests = 0, n_fail = 0;

    logic [15:0] ref_mem [256];
    bit          ref_wel = 1'b0;

    logic  exp_b [$];
    string exp_t [$];
    event  smp;

    always #2 clk = ~clk;

    // protect block model: addresses at or above the boundary are protected
    assign prot_hit = (int'(prot_addr) >= prot_lim);

    sereep_slave #(.ADDR_W(8), .DATA_W(16), .WR_CYCLES(WR_CYC)) i_sereep_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel),
        .sclk_i     (sclk),
        .din_i      (din),
        .prot_sel_i (pre),
        .wr_allow_i (pe),
        .prot_hit_i (prot_hit),
        .prot_addr_o(prot_addr),
        .dout_o     (dout),
        .dout_oe_o  (dout_oe)
    );

    // monitor: pops expected read bits and compares
    always @(smp) begin
        if (exp_b.size() > 0) begin
            logic  e;
            string t;
            e = exp_b.pop_front();
            t = exp_t.pop_front();
            n_tests++;
            if (dout !== e || dout_oe !== 1'b1) begin
                n_fail++;
                $display("FAIL %s: dout=%b oe=%b expected dout=%b oe=1", t, dout, dout_oe, e);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic send_bit(input logic b, input bit chk);
        @(negedge clk) din = b; sclk = 1'b0;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        if (chk) -> smp;
    endtask

    task automatic send_hdr(input int lead, input logic [1:0] opc, input logic [7:0] a, input bit chk_last);
        for (int i = 0; i < lead; i++) send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(opc[1], 1'b0);
        send_bit(opc[0], 1'b0);
        for (int i = 7; i >= 0; i--) send_bit(a[i], (i == 0) && chk_last);
    endtask

    task automatic cmd_start();
        @(negedge clk) sel = 1'b1; sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cmd_end();
        @(negedge clk) sel = 1'b0; sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] a, input int nw, input int lead, input string tag);
        exp_b.push_back(1'b0); exp_t.push_back({tag, " dummy"});
        for (int w = 0; w < nw; w++) begin
            logic [15:0] v;
            v = ref_mem[8'(int'(a) + w)];
            for (int b = 15; b >= 0; b--) begin
                exp_b.push_back(v[b]); exp_t.push_back(tag);
            end
        end
        cmd_start();
        send_hdr(lead, 2'b10, a, 1'b1);
        for (int i = 0; i < nw * 16; i++) send_bit(1'b0, 1'b1);
        cmd_end();
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        cmd_start();
        send_hdr(0, 2'b01, a, 1'b0);
        for (int i = 15; i >= 0; i--) send_bit(d[i], 1'b0);
        cmd_end();
        if (ref_wel && pe && !pre && int'(a) < prot_lim) ref_mem[a] = d;
        repeat (300) @(negedge clk);
    endtask

    task automatic do_fill(input logic [15:0] d);
        cmd_start();
        send_hdr(0, 2'b00, 8'h40, 1'b0);
        for (int i = 15; i >= 0; i--) send_bit(d[i], 1'b0);
        cmd_end();
        if (ref_wel && pe && !pre)
            for (int i = 0; i < prot_lim && i < 256; i++) ref_mem[i] = d;
        repeat (300) @(negedge clk);
    endtask

    task automatic do_short(input logic [7:0] a);
        cmd_start();
        send_hdr(0, 2'b00, a, 1'b0);
        cmd_end();
        if (!pre && a[7:6] == 2'b11 && pe) ref_wel = 1'b1;
        if (!pre && a[7:6] == 2'b00) ref_wel = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11: reset state
        check(dout_oe == 1'b0, "R11 oe after reset", int'(dout_oe), 0);
        do_read(8'h00, 1, 0, "R11 erased word");

        // R8: write with latch clear is ignored (R7 latch reset)
        pe = 1'b1;
        do_write(8'h05, 16'h1234);
        do_read(8'h05, 1, 0, "R7 latch clear after reset blocks write");

        // R7 unlock, R8 write, R10 status window
        do_short(8'hC0);
        cmd_start();
        send_hdr(0, 2'b01, 8'h05, 1'b0);
        for (int i = 15; i >= 0; i--) send_bit(1'(16'hA5C3 >> i), 1'b0);
        cmd_end();
        ref_mem[5] = 16'hA5C3;
        @(negedge clk) sel = 1'b1;
        repeat (2) @(negedge clk);
        check(dout_oe && dout == 1'b0, "R10 busy shown", int'({dout_oe, dout}), 2);
        repeat (WR_CYC + 10) @(negedge clk);
        check(dout_oe && dout == 1'b1, "R10 ready shown", int'({dout_oe, dout}), 3);
        cmd_end();
        do_read(8'h05, 1, 0, "R8 word written");
        do_read(8'h05, 1, 3, "R3 leading zeros");

        // R5/R6: sequential read with wrap
        do_write(8'hFF, 16'h0F0F);
        do_write(8'h00, 16'hC001);
        do_write(8'hFE, 16'h7E81);
        do_read(8'hFE, 3, 0, "R6 wrap 255 to 0");
        do_read(8'h04, 3, 0, "R5 sequential words");

        // R8: program enable low blocks write
        pe = 1'b0;
        do_write(8'h05, 16'h0000);
        pe = 1'b1;
        do_read(8'h05, 1, 0, "R8 program enable low");

        // R8: protected address ignored, unprotected written
        prot_lim = 200;
        do_write(8'hD2, 16'h5555);
        do_write(8'h64, 16'hBEEF);
        do_read(8'hD2, 1, 0, "R8 protected word kept");
        do_read(8'h64, 1, 0, "R8 unprotected word stored");

        // R9: fill below boundary only
        do_fill(16'h3C3C);
        do_read(8'hC6, 3, 0, "R9 fill across boundary");
        do_read(8'hFE, 3, 0, "R9 fill top kept and low filled");
        prot_lim = 256;

        // R4: protect-select high and unlisted code do nothing
        pre = 1'b1;
        do_write(8'h10, 16'h9999);
        pre = 1'b0;
        do_short(8'h80);
        do_read(8'h10, 1, 0, "R4 protect-select high ignored");

        // R1: activity while deselected
        for (int i = 0; i < 20; i++) begin
            @(negedge clk) sclk = ~sclk; din = i[0];
        end
        check(dout_oe == 1'b0, "R1 oe low while deselected", int'(dout_oe), 0);
        send_hdr(0, 2'b01, 8'h11, 1'b0);
        for (int i = 0; i < 16; i++) send_bit(1'b0, 1'b0);
        check(dout_oe == 1'b0, "R1 oe low after clocking", int'(dout_oe), 0);
        repeat (300) @(negedge clk);
        do_read(8'h11, 1, 0, "R1 deselected frame ignored");

        // R2: cut-short frame and restart
        cmd_start();
        send_hdr(0, 2'b01, 8'h12, 1'b0);
        for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b0);
        cmd_end();
        repeat (300) @(negedge clk);
        cmd_start();
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        cmd_end();
        do_read(8'h12, 1, 0, "R2 cut frame commits nothing and restart works");

        // R7: lock blocks later writes
        do_short(8'h00);
        do_write(8'h05, 16'h0000);
        do_read(8'h05, 1, 0, "R7 lock blocks write");

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule